// File: doc/BRIEF.md
# Debug Host Serial Controller

This block sits on the host side of a target's background debug link. It owns three jobs. It can request a breakpoint from the target through an active-low request line. It clocks fixed-width command frames out to the target and collects the bits the target returns. It then waits for the target to signal that it is ready for the next frame. The host is always the master of the link and generates every serial clock edge itself. The target only ever answers.

A host agent issues one command at a time on a valid/ready port and receives exactly one single-cycle response for each accepted command. There are two ways to request a breakpoint. The first asserts the request for exactly the length of the next target bus cycle. The second asserts the request and holds it until the target reports that it has halted.

Serial frames run only while the target's halted indication is high, and each clock phase is stretched so that the target's input synchronizers can follow. After a frame, the block waits for the target's serial output to change level. A timeout limits that wait.

Top module: `dbg_host_ctrl`

## Requirements
- R1: Out of reset, brk_req_n is 1, ser_clk is 0, ser_out is 0, cmd_ready is 1 and rsp_valid is 0.
- R2: cmd_op selects the command: 0 runs a serial frame, 1 runs a bus-cycle breakpoint, 2 runs a hold-until-halted breakpoint, and 3 is ignored. An ignored command produces no response, leaves cmd_ready at 1 and leaves brk_req_n and ser_clk idle.
- R3: For a bus-cycle breakpoint, brk_req_n stays 1 until the first clock of the next rising bus_cycle. A bus cycle already in progress at acceptance does not count. From the clock after that first clock, brk_req_n is 0 for exactly as many clocks as bus_cycle is high. A response with status 0 (done) follows.
- R4: For a hold breakpoint, brk_req_n falls on the clock after acceptance. It stays 0 until tgt_halted is sampled high and returns to 1 on the next clock. A response with status 0 follows.
- R5: ser_clk stays 0 whenever brk_req_n is 0 and whenever the controller is idle.
- R6: A frame is FRAME_W bits, sent most significant bit first on ser_out. Each bit has a ser_clk low phase followed by a high phase, each exactly HALF_CLKS clocks long. ser_out changes only while ser_clk is 0.
- R7: ser_in is sampled on the last clock of each high phase. The samples are assembled most significant bit first into rsp_data.
- R8: After the last bit, no response is given until ser_in differs from its level at the end of the frame. Then a response with status 0 carries the collected word.
- R9: If ser_in does not change, the response comes with status 1 (timeout) on the TIMEOUT_CLKS+2nd clock after the final falling ser_clk. The controller then returns to idle.
- R10: A frame command accepted while tgt_halted is 0 is answered on the next clock with status 2 (aborted) and produces no ser_clk edge.
- R11: If tgt_halted falls during a frame, ser_clk is 0 on the next clock and the frame produces no further edge. A response with status 2 follows.
- R12: rsp_valid is high for exactly one clock per accepted command, and rsp_status is never 3. cmd_ready is 0 from acceptance until that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code (R2) |
| cmd_data | input | FRAME_W | Frame word to send |
| cmd_ready | output | 1 | Controller idle, command accepted when valid |
| rsp_valid | output | 1 | One-clock response strobe |
| rsp_status | output | 2 | 0 done, 1 timeout, 2 aborted |
| rsp_data | output | FRAME_W | Word collected from the target |
| bus_cycle | input | 1 | High while a target bus cycle runs |
| brk_req_n | output | 1 | Active-low breakpoint request |
| tgt_halted | input | 1 | Target reports it is halted in debug mode |
| ser_clk | output | 1 | Host-generated serial clock |
| ser_out | output | 1 | Serial data to the target |
| ser_in | input | 1 | Serial data from the target |

## Verification
The bench sweeps the bus-cycle breakpoint over bus cycle lengths of one to five clocks, and also starts it inside a bus cycle that is already running. A design that latched on a level instead of an edge would fire early, and one with an off-by-one release would hold the request a clock too long.

It sweeps the hold breakpoint over several halt delays, and runs frames with edge-case words: all zeros, all ones, a single top bit and a single bottom bit. It measures every clock phase and checks bit order in both directions. A swapped bit order or a short phase shows up directly.

The ready wait is checked twice. One run delays the target's change to prove that no response leaks out early. Another run never changes the line, so the timeout lands on an exact clock. Finally, the halt indication is dropped both before and during a frame, which catches a design that keeps clocking a target that has left debug mode.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  typedef enum logic [1:0] {
    OP_FRAME    = 2'd0,
    OP_BRK_BUS  = 2'd1,
    OP_BRK_HOLD = 2'd2,
    OP_RSVD     = 2'd3
  } dbg_op_e;

  typedef enum logic [1:0] {
    ST_DONE    = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_ABORT   = 2'd2
  } dbg_status_e;

endpackage

// File: rtl/dbg_brk_gen.sv
module dbg_brk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hold_mode,
  input  logic bus_cycle,
  input  logic tgt_halted,
  output logic brk_req_n,
  output logic done
);

  typedef enum logic [1:0] {B_IDLE, B_ARM, B_LOW} brk_state_e;

  brk_state_e st_q, st_d;
  logic       hold_q, hold_d;
  logic       bus_q;
  logic       done_d;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    done_d = 1'b0;
    case (st_q)
      B_IDLE: begin
        if (start) begin
          hold_d = hold_mode;
          st_d   = hold_mode ? B_LOW : B_ARM;
        end
      end
      B_ARM: begin
        // only a fresh bus cycle qualifies
        if (bus_cycle && !bus_q) st_d = B_LOW;
      end
      B_LOW: begin
        if (hold_q ? tgt_halted : !bus_cycle) begin
          st_d   = B_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = B_IDLE;
    endcase
  end

  // registers; request pin comes straight from a flop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= B_IDLE;
      hold_q    <= 1'b0;
      bus_q     <= 1'b0;
      brk_req_n <= 1'b1;
      done      <= 1'b0;
    end else begin
      st_q      <= st_d;
      hold_q    <= hold_d;
      bus_q     <= bus_cycle;
      brk_req_n <= (st_d != B_LOW);
      done      <= done_d;
    end
  end

endmodule

// File: rtl/dbg_frame_shifter.sv
module dbg_frame_shifter #(
  parameter int FRAME_W   = 17,
  parameter int HALF_CLKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] data_in,
  input  logic               tgt_halted,
  input  logic               ser_in,
  output logic               ser_clk,
  output logic               ser_out,
  output logic               busy,
  output logic               done,
  output logic               abort,
  output logic [FRAME_W-1:0] data_out
);

  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam int BW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  logic [CW-1:0]      cnt_q, cnt_d;
  logic [BW-1:0]      bit_q, bit_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic               clk_q, clk_d;
  logic               busy_q, busy_d;
  logic               done_d, abort_d;

  always_comb begin
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    clk_d   = clk_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    abort_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        tx_d   = data_in;
        rx_d   = '0;
        clk_d  = 1'b0;
        cnt_d  = '0;
        bit_d  = '0;
      end
    end else if (!tgt_halted) begin
      // target left debug mode: park the clock low at once
      busy_d  = 1'b0;
      clk_d   = 1'b0;
      abort_d = 1'b1;
    end else if (cnt_q == CW'(HALF_CLKS - 1)) begin
      cnt_d = '0;
      if (!clk_q) begin
        clk_d = 1'b1;
      end else begin
        clk_d = 1'b0;
        rx_d  = {rx_q[FRAME_W-2:0], ser_in};
        if (bit_q == BW'(FRAME_W - 1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          tx_d  = {tx_q[FRAME_W-2:0], 1'b0};
        end
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      clk_q  <= 1'b0;
      busy_q <= 1'b0;
      done   <= 1'b0;
      abort  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      clk_q  <= clk_d;
      busy_q <= busy_d;
      done   <= done_d;
      abort  <= abort_d;
    end
  end

  assign ser_clk  = clk_q;
  assign ser_out  = tx_q[FRAME_W-1];
  assign busy     = busy_q;
  assign data_out = rx_q;

endmodule

// File: rtl/dbg_ready_watch.sv
module dbg_ready_watch #(
  parameter int TIMEOUT_CLKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  input  logic ser_in,
  output logic ready,
  output logic expired
);

  localparam int TW = $clog2(TIMEOUT_CLKS + 1);

  logic          act_q, act_d;
  logic          ref_q, ref_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          ready_d, expired_d;

  always_comb begin
    act_d     = act_q;
    ref_d     = ref_q;
    cnt_d     = cnt_q;
    ready_d   = 1'b0;
    expired_d = 1'b0;
    if (start) begin
      act_d = 1'b1;
      ref_d = ser_in;
      cnt_d = '0;
    end else if (act_q) begin
      if (cancel) begin
        act_d = 1'b0;
      end else if (ser_in != ref_q) begin
        act_d   = 1'b0;
        ready_d = 1'b1;
      end else if (cnt_q == TW'(TIMEOUT_CLKS - 1)) begin
        act_d     = 1'b0;
        expired_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      ref_q   <= 1'b0;
      cnt_q   <= '0;
      ready   <= 1'b0;
      expired <= 1'b0;
    end else begin
      act_q   <= act_d;
      ref_q   <= ref_d;
      cnt_q   <= cnt_d;
      ready   <= ready_d;
      expired <= expired_d;
    end
  end

endmodule

// File: rtl/dbg_host_ctrl.sv
module dbg_host_ctrl
  import dbg_pkg::*;
#(
  parameter int FRAME_W      = 17,
  parameter int HALF_CLKS    = 4,
  parameter int TIMEOUT_CLKS = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [FRAME_W-1:0] cmd_data,
  output logic               cmd_ready,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [FRAME_W-1:0] rsp_data,
  input  logic               bus_cycle,
  output logic               brk_req_n,
  input  logic               tgt_halted,
  output logic               ser_clk,
  output logic               ser_out,
  input  logic               ser_in
);

  typedef enum logic [1:0] {T_IDLE, T_BRK, T_SHIFT, T_WAIT} top_state_e;

  top_state_e         st_q, st_d;
  dbg_op_e            op;
  logic               accept;
  logic               brk_start, sh_start;
  logic               brk_done;
  logic               sh_busy, sh_done, sh_abort;
  logic [FRAME_W-1:0] sh_rx;
  logic               rdy_hit, rdy_expired, rdy_cancel;
  logic               rsp_valid_d;
  logic [1:0]         rsp_status_d;
  logic [FRAME_W-1:0] rsp_data_d;

  assign op         = dbg_op_e'(cmd_op);
  assign cmd_ready  = (st_q == T_IDLE);
  assign accept     = cmd_valid && cmd_ready && (op != OP_RSVD);
  assign brk_start  = accept && ((op == OP_BRK_BUS) || (op == OP_BRK_HOLD));
  assign sh_start   = accept && (op == OP_FRAME) && tgt_halted;
  assign rdy_cancel = (st_q == T_WAIT) && !tgt_halted;

  dbg_brk_gen u_brk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (brk_start),
    .hold_mode  (op == OP_BRK_HOLD),
    .bus_cycle  (bus_cycle),
    .tgt_halted (tgt_halted),
    .brk_req_n  (brk_req_n),
    .done       (brk_done)
  );

  dbg_frame_shifter #(
    .FRAME_W   (FRAME_W),
    .HALF_CLKS (HALF_CLKS)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (sh_start),
    .data_in    (cmd_data),
    .tgt_halted (tgt_halted),
    .ser_in     (ser_in),
    .ser_clk    (ser_clk),
    .ser_out    (ser_out),
    .busy       (sh_busy),
    .done       (sh_done),
    .abort      (sh_abort),
    .data_out   (sh_rx)
  );

  dbg_ready_watch #(
    .TIMEOUT_CLKS (TIMEOUT_CLKS)
  ) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_done),
    .cancel  (rdy_cancel),
    .ser_in  (ser_in),
    .ready   (rdy_hit),
    .expired (rdy_expired)
  );

  // sequencing and response assembly
  always_comb begin
    st_d         = st_q;
    rsp_valid_d  = 1'b0;
    rsp_status_d = rsp_status;
    rsp_data_d   = rsp_data;
    case (st_q)
      T_IDLE: begin
        if (accept) begin
          if (op == OP_FRAME) begin
            if (tgt_halted) begin
              st_d = T_SHIFT;
            end else begin
              rsp_valid_d  = 1'b1;
              rsp_status_d = ST_ABORT;
              rsp_data_d   = '0;
            end
          end else begin
            st_d = T_BRK;
          end
        end
      end
      T_BRK: begin
        if (brk_done) begin
          st_d         = T_IDLE;
          rsp_valid_d  = 1'b1;
          rsp_status_d = ST_DONE;
          rsp_data_d   = '0;
        end
      end
      T_SHIFT: begin
        if (sh_abort) begin
          st_d         = T_IDLE;
          rsp_valid_d  = 1'b1;
          rsp_status_d = ST_ABORT;
          rsp_data_d   = sh_rx;
        end else if (sh_done && !sh_busy) begin
          st_d = T_WAIT;
        end
      end
      T_WAIT: begin
        if (!tgt_halted) begin
          st_d         = T_IDLE;
          rsp_valid_d  = 1'b1;
          rsp_status_d = ST_ABORT;
          rsp_data_d   = sh_rx;
        end else if (rdy_hit) begin
          st_d         = T_IDLE;
          rsp_valid_d  = 1'b1;
          rsp_status_d = ST_DONE;
          rsp_data_d   = sh_rx;
        end else if (rdy_expired) begin
          st_d         = T_IDLE;
          rsp_valid_d  = 1'b1;
          rsp_status_d = ST_TIMEOUT;
          rsp_data_d   = sh_rx;
        end
      end
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= T_IDLE;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_DONE;
      rsp_data   <= '0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= rsp_valid_d;
      if (rsp_valid_d) begin
        rsp_status <= rsp_status_d;
        rsp_data   <= rsp_data_d;
      end
    end
  end

endmodule

// File: rtl/dbg_host_ctrl_chk.sv
module dbg_host_ctrl_chk #(
  parameter int HALF_CLKS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       brk_req_n,
  input logic       ser_clk,
  input logic       ser_out,
  input logic       tgt_halted,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic [1:0] rsp_status
);

  localparam int LW = $clog2(HALF_CLKS + 1);

  logic          clk_prev;
  logic [LW-1:0] run_len;

  // length of the level ser_clk held before its latest change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b0;
      run_len  <= LW'(HALF_CLKS);
    end else begin
      clk_prev <= ser_clk;
      if (ser_clk != clk_prev) run_len <= LW'(1);
      else if (run_len < LW'(HALF_CLKS)) run_len <= run_len + 1'b1;
    end
  end

  AST_BRK_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req_n |-> !ser_clk); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (brk_req_n && !ser_clk)); // R5
  AST_LOW_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && !clk_prev) |-> (run_len >= LW'(HALF_CLKS))); // R6
  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_clk && clk_prev && $past(tgt_halted)) |-> (run_len >= LW'(HALF_CLKS))); // R6
  AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_out) |-> !ser_clk); // R6
  AST_RISE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && !clk_prev) |-> $past(tgt_halted)); // R11
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R12
  AST_RSP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd3)); // R12

endmodule

bind dbg_host_ctrl dbg_host_ctrl_chk #(.HALF_CLKS(HALF_CLKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .brk_req_n  (brk_req_n),
  .ser_clk    (ser_clk),
  .ser_out    (ser_out),
  .tgt_halted (tgt_halted),
  .cmd_ready  (cmd_ready),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status)
);

// File: tb/dbg_host_ctrl_tb.sv
module dbg_host_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 17;
  localparam int HALF = 3;
  localparam int TO   = 40;

  logic         clk;
  logic         rst_n;
  logic         cmd_valid;
  logic [1:0]   cmd_op;
  logic [W-1:0] cmd_data;
  logic         cmd_ready;
  logic         rsp_valid;
  logic [1:0]   rsp_status;
  logic [W-1:0] rsp_data;
  logic         bus_cycle;
  logic         brk_req_n;
  logic         tgt_halted;
  logic         ser_clk;
  logic         ser_out;
  logic         ser_in;

  int n_chk;
  int n_bad;

  dbg_host_ctrl #(
    .FRAME_W      (W),
    .HALF_CLKS    (HALF),
    .TIMEOUT_CLKS (TO)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_data   (cmd_data),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_data   (rsp_data),
    .bus_cycle  (bus_cycle),
    .brk_req_n  (brk_req_n),
    .tgt_halted (tgt_halted),
    .ser_clk    (ser_clk),
    .ser_out    (ser_out),
    .ser_in     (ser_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [W-1:0] data);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int limit, output int cycles);
    cycles = 0;
    while (!rsp_valid && cycles < limit) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  // target model for one frame; ends at the first negedge after the last fall
  task automatic run_frame(input logic [W-1:0] word, input logic [W-1:0] reply);
    for (int i = W - 1; i >= 0; i--) begin
      int lo;
      int hi;
      lo = 0;
      while (!ser_clk && lo < 100) begin
        lo++;
        @(negedge clk);
      end
      check(lo == HALF, "R6 low phase", lo, HALF);
      check(ser_out == word[i], "R6 bit order", ser_out, word[i]);
      ser_in = reply[i];
      hi = 0;
      while (ser_clk && hi < 100) begin
        hi++;
        @(negedge clk);
      end
      check(hi == HALF, "R6 high phase", hi, HALF);
    end
  endtask

  task automatic frame_ok(input logic [W-1:0] word, input logic [W-1:0] reply, input int delay);
    int c;
    tgt_halted = 1'b1;
    send(2'd0, word);
    check(cmd_ready == 1'b0, "R12 busy after accept", cmd_ready, 0);
    run_frame(word, reply);
    for (int k = 0; k < delay; k++) begin
      check(rsp_valid == 1'b0, "R8 no early response", rsp_valid, 0);
      @(negedge clk);
    end
    ser_in = ~ser_in;
    wait_rsp(TO + 10, c);
    check(rsp_valid && rsp_status == 2'd0, "R8 ready response", rsp_status, 0);
    check(rsp_data == reply, "R7 collected word", rsp_data, reply);
    check(cmd_ready == 1'b1, "R12 idle with response", cmd_ready, 1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R12 single pulse", rsp_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R12: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c;
    int lowcnt;
    bit seen;
    logic [W-1:0] lfsr;
    n_chk      = 0;
    n_bad      = 0;
    rst_n      = 1'b0;
    cmd_valid  = 1'b0;
    cmd_op     = 2'd0;
    cmd_data   = '0;
    bus_cycle  = 1'b0;
    tgt_halted = 1'b0;
    ser_in     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(brk_req_n == 1'b1, "R1 brk_req_n", brk_req_n, 1);
    check(ser_clk == 1'b0, "R1 ser_clk", ser_clk, 0);
    check(ser_out == 1'b0, "R1 ser_out", ser_out, 0);
    check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);

    // R2 reserved code is ignored
    send(2'd3, 17'h1ffff);
    for (int k = 0; k < 15; k++) begin
      check(!rsp_valid && cmd_ready && brk_req_n && !ser_clk, "R2 reserved ignored",
            {rsp_valid, cmd_ready, brk_req_n, ser_clk}, 4'b0110);
      @(negedge clk);
    end

    // R3 a bus cycle already running at acceptance does not count
    bus_cycle = 1'b1;
    send(2'd1, '0);
    for (int k = 0; k < 4; k++) begin
      check(brk_req_n == 1'b1, "R3 ignores running cycle", brk_req_n, 1);
      @(negedge clk);
    end
    bus_cycle = 1'b0;
    repeat (2) @(negedge clk);

    // R3 sweep of bus cycle lengths (first case reuses the armed request)
    for (int len = 1; len <= 5; len++) begin
      if (len > 1) begin
        send(2'd1, '0);
        for (int k = 0; k < 3; k++) begin
          check(brk_req_n == 1'b1, "R3 waits for bus cycle", brk_req_n, 1);
          @(negedge clk);
        end
      end
      bus_cycle = 1'b1;
      lowcnt = 0;
      seen = 1'b0;
      for (int k = 1; k <= len + 6; k++) begin
        @(negedge clk);
        if (!brk_req_n) lowcnt++;
        check(ser_clk == 1'b0, "R5 clock quiet in breakpoint", ser_clk, 0);
        if (rsp_valid) begin
          seen = 1'b1;
          check(rsp_status == 2'd0, "R3 response status", rsp_status, 0);
        end
        if (k == len) bus_cycle = 1'b0;
      end
      check(lowcnt == len, "R3 request length", lowcnt, len);
      check(seen, "R3 response given", seen, 1);
    end

    // R4 hold breakpoint sweep of halt delays
    for (int d = 0; d <= 4; d++) begin
      tgt_halted = 1'b0;
      send(2'd2, '0);
      check(brk_req_n == 1'b0, "R4 request asserted", brk_req_n, 0);
      for (int k = 0; k < d; k++) begin
        @(negedge clk);
        check(brk_req_n == 1'b0 && !ser_clk, "R4 request held", brk_req_n, 0);
      end
      tgt_halted = 1'b1;
      @(negedge clk);
      check(brk_req_n == 1'b1, "R4 release after halt", brk_req_n, 1);
      wait_rsp(4, c);
      check(rsp_valid && rsp_status == 2'd0, "R4 response", rsp_status, 0);
      @(negedge clk);
    end
    tgt_halted = 1'b0;

    // R10 frame refused while target is running
    send(2'd0, 17'h12345);
    check(rsp_valid && rsp_status == 2'd2, "R10 immediate abort", rsp_status, 2);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(ser_clk == 1'b0, "R10 no clock", ser_clk, 0);
    end

    // R6 R7 R8 frames over edge words and computed words
    frame_ok(17'h00000, 17'h1ffff, 1);
    frame_ok(17'h1ffff, 17'h00000, 2);
    frame_ok(17'h10000, 17'h00001, 3);
    frame_ok(17'h00001, 17'h10000, 10);
    lfsr = 17'h0b5a3;
    for (int t = 0; t < 6; t++) begin
      lfsr = {lfsr[W-2:0], lfsr[16] ^ lfsr[13]};
      frame_ok(lfsr, ~{lfsr[7:0], lfsr[16:8]}, 1 + t % 4);
    end

    // R9 timeout with no ready change
    tgt_halted = 1'b1;
    send(2'd0, 17'h0f0f0);
    run_frame(17'h0f0f0, 17'h15555);
    c = 0;
    while (!rsp_valid && c < TO + 20) begin
      @(negedge clk);
      c++;
    end
    check(c == TO + 2, "R9 timeout clock", c, TO + 2);
    check(rsp_status == 2'd1, "R9 timeout status", rsp_status, 1);
    check(rsp_data == 17'h15555, "R9 data kept", rsp_data, 17'h15555);
    check(cmd_ready == 1'b1, "R9 back to idle", cmd_ready, 1);
    @(negedge clk);

    // R11 halt drops during a frame
    send(2'd0, 17'h1a5a5);
    c = 0;
    while (c < 3) begin
      if (ser_clk) begin
        c++;
        if (c < 3) while (ser_clk) @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
    tgt_halted = 1'b0;
    @(negedge clk);
    check(ser_clk == 1'b0, "R11 clock parked", ser_clk, 0);
    wait_rsp(5, c);
    check(rsp_valid && rsp_status == 2'd2, "R11 abort status", rsp_status, 2);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(ser_clk == 1'b0, "R11 no further edges", ser_clk, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule